// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory and watches the enable and address of the left and right ports. When both ports are enabled on the same address, the port that got there first keeps going. The other port receives a busy flag, and any write it presents is held off internally until the collision clears. The arbitration uses only enable and address. Whether either access is a read or a write plays no part.

A mode strap picks between two roles. In master mode the block decides collisions itself and drives a busy flag for each port. In slave mode, used when several arrays are ganged for a wider word, the busy flags come in from an external master. They then act only as per-port write inhibits, and the block's own busy outputs stay low.

All port inputs are registered once on the rising clock edge. The busy flags and the write qualifiers respond to inputs sampled at the previous edge. A port counts as newly arrived in a cycle when its enable has just risen or its address has just changed.

Top module: `dpca_arbiter`

## Requirements
- R1: When either port is disabled or the two registered addresses differ, both busy outputs are 0 and each enabled write passes to its write-enable output.
- R2: When a collision begins, the port whose enable and address were already held from the previous cycle wins, and busy (active high) goes to the other port only. Busy stays on that port for as long as the collision lasts.
- R3: The two busy outputs are never 1 in the same cycle.
- R4: A port's read or write direction never changes which port is busy.
- R5: In master mode a port whose busy is 1 has its write-enable output forced to 0. The busy inputs have no effect in this mode.
- R6: In slave mode (mode input 1) both busy outputs are 0. A busy input of 1 forces that port's write-enable output to 0, and a busy input of 0 leaves the port's writes unaffected.
- R7: When the winner's enable drops or the addresses stop matching, the loser's busy clears in the next output cycle, and its pending write then goes through.
- R8: When both ports start a matching access in the same cycle, the left port wins and the right port is busy.
- R9: An active-low reset clears all collision state and forces both busy outputs and both write-enable outputs to 0.

Outputs reflect inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_mode | input | 1 | 0 selects master, 1 selects slave |
| l_en | input | 1 | Left port access enable |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write request |
| l_busy_in | input | 1 | Left busy from an external master, used in slave mode |
| r_en | input | 1 | Right port access enable |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write request |
| r_busy_in | input | 1 | Right busy from an external master, used in slave mode |
| l_busy | output | 1 | Left port lost arbitration |
| r_busy | output | 1 | Right port lost arbitration |
| l_wr_ok | output | 1 | Left write enable after busy qualification |
| r_wr_ok | output | 1 | Right write enable after busy qualification |

## Verification
Two decisions can land in the same cycle: arbitration between two accesses that arrive together, and the gating of a write from the port that loses. The bench starts matching writes on both ports in one cycle. It expects the right port to be busy and only the left write to pass. It then pulls away the winner while the loser still holds its write, and checks that the write goes through one output cycle later. Slave-mode vectors use a single busy input to block one port while the other is left free.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

   localparam int PORTS = 2;
   localparam int LEFT  = 0;
   localparam int RIGHT = 1;
endpackage

// File: rtl/dpca_port_stage.sv
module dpca_port_stage #(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              busy_in,
   output logic              q_en,
   output logic [ADDR_W-1:0] q_addr,
   output logic              q_wr,
   output logic              q_busy_in,
   output logic              fresh
);
   logic              p_en;
   logic [ADDR_W-1:0] p_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_en      <= 1'b0;
         q_addr    <= '0;
         q_wr      <= 1'b0;
         q_busy_in <= 1'b0;
         p_en      <= 1'b0;
         p_addr    <= '0;
      end else begin
         q_en      <= en;
         q_addr    <= addr;
         q_wr      <= wr;
         q_busy_in <= busy_in;
         p_en      <= q_en;
         p_addr    <= q_addr;
      end
   end

   // the access is new if the enable just rose or the address just moved
   always_comb fresh = q_en && (!p_en || (p_addr != q_addr));
endmodule

// File: rtl/dpca_addr_match.sv
module dpca_addr_match #(
   parameter int ADDR_W = 13
) (
   input  logic              a_en,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              b_en,
   input  logic [ADDR_W-1:0] b_addr,
   output logic              hit
);
   logic [ADDR_W-1:0] bit_eq;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      assign bit_eq[i] = ~(a_addr[i] ^ b_addr[i]);
   end

   assign hit = a_en && b_en && (&bit_eq);
endmodule

// File: rtl/dpca_owner_fsm.sv
module dpca_owner_fsm
   import dpca_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   hit,
   input  logic   fresh_l,
   input  logic   fresh_r,
   output owner_e owner
);
   owner_e owner_q;

   always_comb begin
      if (!hit)
         owner = OWN_NONE;
      else if (owner_q != OWN_NONE)
         owner = owner_q;
      else if (fresh_l && !fresh_r)
         owner = OWN_RIGHT;
      else
         owner = OWN_LEFT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= OWN_NONE;
      else        owner_q <= owner;
   end
endmodule

// File: rtl/dpca_write_gate.sv
module dpca_write_gate (
   input  logic slave_mode,
   input  logic q_en,
   input  logic q_wr,
   input  logic q_busy_in,
   input  logic lost,
   output logic busy_o,
   output logic wr_ok
);
   logic inhibit;

   always_comb begin
      busy_o  = !slave_mode && lost;
      inhibit = slave_mode ? q_busy_in : lost;
      wr_ok   = q_en && q_wr && !inhibit;
   end
endmodule

// File: rtl/dpca_arbiter.sv
module dpca_arbiter
   import dpca_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slave_mode,
   input  logic              l_en,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_wr,
   input  logic              l_busy_in,
   input  logic              r_en,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_wr,
   input  logic              r_busy_in,
   output logic              l_busy,
   output logic              r_busy,
   output logic              l_wr_ok,
   output logic              r_wr_ok
);
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_width
      $error("dpca_arbiter: ADDR_W must lie in 1..32");
   end

   logic [PORTS-1:0]  in_en, in_wr, in_bin;
   logic [ADDR_W-1:0] in_addr [PORTS];
   logic [PORTS-1:0]  q_en, q_wr, q_bin, fresh, lost, busy_v, wr_ok_v;
   logic [ADDR_W-1:0] q_addr [PORTS];
   logic              hit;
   owner_e            owner;

   assign in_en         = {r_en, l_en};
   assign in_wr         = {r_wr, l_wr};
   assign in_bin        = {r_busy_in, l_busy_in};
   assign in_addr[LEFT]  = l_addr;
   assign in_addr[RIGHT] = r_addr;

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      dpca_port_stage #(.ADDR_W(ADDR_W)) u_stage (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (in_en[p]),
         .addr      (in_addr[p]),
         .wr        (in_wr[p]),
         .busy_in   (in_bin[p]),
         .q_en      (q_en[p]),
         .q_addr    (q_addr[p]),
         .q_wr      (q_wr[p]),
         .q_busy_in (q_bin[p]),
         .fresh     (fresh[p])
      );

      dpca_write_gate u_gate (
         .slave_mode (slave_mode),
         .q_en       (q_en[p]),
         .q_wr       (q_wr[p]),
         .q_busy_in  (q_bin[p]),
         .lost       (lost[p]),
         .busy_o     (busy_v[p]),
         .wr_ok      (wr_ok_v[p])
      );
   end

   dpca_addr_match #(.ADDR_W(ADDR_W)) u_match (
      .a_en   (q_en[LEFT]),
      .a_addr (q_addr[LEFT]),
      .b_en   (q_en[RIGHT]),
      .b_addr (q_addr[RIGHT]),
      .hit    (hit)
   );

   dpca_owner_fsm u_owner (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .fresh_l (fresh[LEFT]),
      .fresh_r (fresh[RIGHT]),
      .owner   (owner)
   );

   assign lost[LEFT]  = (owner == OWN_RIGHT);
   assign lost[RIGHT] = (owner == OWN_LEFT);

   assign l_busy  = busy_v[LEFT];
   assign r_busy  = busy_v[RIGHT];
   assign l_wr_ok = wr_ok_v[LEFT];
   assign r_wr_ok = wr_ok_v[RIGHT];
endmodule

// File: rtl/dpca_arbiter_chk.sv
module dpca_arbiter_chk #(
   parameter int ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              slave_mode,
   input logic              l_en,
   input logic [ADDR_W-1:0] l_addr,
   input logic              r_en,
   input logic [ADDR_W-1:0] r_addr,
   input logic              l_busy_in,
   input logic              r_busy_in,
   input logic              l_busy,
   input logic              r_busy,
   input logic              l_wr_ok,
   input logic              r_wr_ok
);
   AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_busy && r_busy)); // R3

   AST_NO_HIT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(l_en) || !$past(r_en) || ($past(l_addr) != $past(r_addr)))
      |-> (!l_busy && !r_busy)); // R1

   AST_LEFT_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      l_busy |-> !l_wr_ok); // R5

   AST_RIGHT_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      r_busy |-> !r_wr_ok); // R5

   AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      slave_mode |-> (!l_busy && !r_busy)); // R6

   AST_SLAVE_LEFT_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_mode && $past(l_busy_in)) |-> !l_wr_ok); // R6

   AST_SLAVE_RIGHT_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_mode && $past(r_busy_in)) |-> !r_wr_ok); // R6
endmodule

bind dpca_arbiter dpca_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .slave_mode (slave_mode),
   .l_en       (l_en),
   .l_addr     (l_addr),
   .r_en       (r_en),
   .r_addr     (r_addr),
   .l_busy_in  (l_busy_in),
   .r_busy_in  (r_busy_in),
   .l_busy     (l_busy),
   .r_busy     (r_busy),
   .l_wr_ok    (l_wr_ok),
   .r_wr_ok    (r_wr_ok)
);

// File: tb/dpca_arbiter_test.sv
`timescale 1ns/1ps
module dpca_arbiter_test;
   localparam int AW = 13;

   typedef struct packed {
      logic          s;
      logic          le;
      logic [AW-1:0] la;
      logic          lw;
      logic          re;
      logic [AW-1:0] ra;
      logic          rw;
      logic          lbi;
      logic          rbi;
      logic [3:0]    exp;   // {l_busy, r_busy, l_wr_ok, r_wr_ok}
      logic [7:0]    rq;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd1}, // R1 idle
      '{1'b0, 1'b1, 13'd5, 1'b1, 1'b0, 13'd0, 1'b0, 1'b0, 1'b0, 4'b0010, 8'd1}, // R1 one port
      '{1'b0, 1'b1, 13'd5, 1'b1, 1'b1, 13'd7, 1'b1, 1'b0, 1'b0, 4'b0011, 8'd1}, // R1 diff addr
      '{1'b0, 1'b1, 13'd5, 1'b1, 1'b1, 13'd5, 1'b1, 1'b0, 1'b0, 4'b0110, 8'd2}, // R2 left first
      '{1'b0, 1'b1, 13'd5, 1'b1, 1'b1, 13'd5, 1'b1, 1'b0, 1'b0, 4'b0110, 8'd2}, // R2 held
      '{1'b0, 1'b1, 13'd5, 1'b1, 1'b1, 13'd5, 1'b0, 1'b0, 1'b0, 4'b0110, 8'd4}, // R4 loser reads
      '{1'b0, 1'b0, 13'd5, 1'b0, 1'b1, 13'd5, 1'b1, 1'b0, 1'b0, 4'b0001, 8'd7}, // R7 winner leaves
      '{1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd1},
      '{1'b0, 1'b0, 13'd0, 1'b0, 1'b1, 13'd9, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd1},
      '{1'b0, 1'b1, 13'd9, 1'b1, 1'b1, 13'd9, 1'b0, 1'b0, 1'b0, 4'b1000, 8'd4}, // R4 reader wins
      '{1'b0, 1'b1, 13'd9, 1'b1, 1'b1, 13'd10,1'b0, 1'b0, 1'b0, 4'b0010, 8'd7}, // R7 addr moves
      '{1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd1},
      '{1'b0, 1'b1, 13'd3, 1'b1, 1'b1, 13'd3, 1'b1, 1'b0, 1'b0, 4'b0110, 8'd8}, // R8 tie
      '{1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd1},
      '{1'b1, 1'b1, 13'd3, 1'b1, 1'b1, 13'd3, 1'b1, 1'b0, 1'b0, 4'b0011, 8'd6}, // R6 free
      '{1'b1, 1'b1, 13'd3, 1'b1, 1'b1, 13'd3, 1'b1, 1'b1, 1'b0, 4'b0001, 8'd6}, // R6 left held
      '{1'b1, 1'b1, 13'd3, 1'b1, 1'b1, 13'd3, 1'b1, 1'b0, 1'b1, 4'b0010, 8'd6}, // R6 right held
      '{1'b0, 1'b1, 13'd3, 1'b1, 1'b1, 13'd3, 1'b1, 1'b1, 1'b0, 4'b0110, 8'd5}, // R5 input ignored
      '{1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slave_mode = 1'b0;
   logic          l_en = 1'b0, r_en = 1'b0, l_wr = 1'b0, r_wr = 1'b0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic          l_busy_in = 1'b0, r_busy_in = 1'b0;
   logic          l_busy, r_busy, l_wr_ok, r_wr_ok;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   dpca_arbiter #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
      .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr), .l_busy_in(l_busy_in),
      .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr), .r_busy_in(r_busy_in),
      .l_busy(l_busy), .r_busy(r_busy), .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
   );

   task automatic check(input string tag, input logic [3:0] exp);
      logic [3:0] act;
      act = {l_busy, r_busy, l_wr_ok, r_wr_ok};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      slave_mode = v.s;
      l_en = v.le; l_addr = v.la; l_wr = v.lw; l_busy_in = v.lbi;
      r_en = v.re; r_addr = v.ra; r_wr = v.rw; r_busy_in = v.rbi;
   endtask

   initial begin
      // R9 reset state while a collision sits on the inputs
      l_en = 1'b1; r_en = 1'b1; l_wr = 1'b1; r_wr = 1'b1;
      l_addr = 13'd4; r_addr = 13'd4;
      repeat (3) @(negedge clk);
      check("R9 reset state", 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 same-cycle start after reset", 4'b0110);
      drive(TBL[NV-1]);
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(TBL[i]);
         @(negedge clk);
         check($sformatf("R%0d vector %0d", TBL[i].rq, i), TBL[i].exp);
         n_chk++;
         if (l_busy && r_busy) begin
            n_fail++;
            $display("FAIL R3 vector %0d actual=11 expected=not both", i);
         end
      end

      // R9 reset in mid-collision clears the held owner
      drive('{1'b0, 1'b0, 13'd0, 1'b0, 1'b1, 13'd8, 1'b1, 1'b0, 1'b0, 4'b0000, 8'd9});
      @(negedge clk);
      drive('{1'b0, 1'b1, 13'd8, 1'b1, 1'b1, 13'd8, 1'b1, 1'b0, 1'b0, 4'b0000, 8'd9});
      @(negedge clk);
      check("R2 right first", 4'b1001);
      rst_n = 1'b0;
      @(negedge clk);
      check("R9 reset mid-collision", 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 tie after reset, left wins", 4'b0110);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule